// File: doc/BRIEF.md
# Descending Quad-Word Stack Engine

This block owns a stack pointer and carries out push and pop commands against a synchronous memory that is one quad word (8 bytes at the default data width) wide. The stack grows toward lower addresses, so the top of the stack is the lowest occupied address. A push first moves the pointer down by one word and then writes the operand at the new top. A pop reads the word at the current top, returns it, and then moves the pointer up by one word. Each command moves exactly one word.

A requester raises a request with an operation select and holds it until it sees a one-cycle acknowledge. The memory port accepts an access in any cycle where the memory signals ready, and it returns read data one cycle after a read is accepted. The pointer changes only when the memory access completes, so a stalled memory leaves the pointer untouched. Commands issued while the pointer is not word aligned are refused with an alignment flag. An optional lower bound refuses a push that would take the pointer below it, or that would wrap below address zero, with an overflow flag and no write.

A load input sets the pointer directly, and a separate input programs the lower bound.

Top module: `stk_engine`

## Requirements
- R1: After reset the pointer reads 0, acknowledge and both fault flags are low, no memory access is driven, and the lower bound is disabled.
- R2: A push (`cmd_pop` = 0) drives a write of `cmd_data` to address pointer−8; when memory is ready the pointer becomes pointer−8 and acknowledge rises one cycle after the write is accepted.
- R3: A pop (`cmd_pop` = 1) drives a read at the pointer; the returned word appears on `rsp_data`, the pointer becomes pointer+8, and acknowledge rises two cycles after the read is accepted.
- R4: With the pointer at 0x108, a push of 0x123 leaves the pointer at 0x100 with 0x123 stored at 0x100; a pop that follows returns 0x123 and restores the pointer to 0x108.
- R5: A pop issues no write, so the popped word stays at its address and is returned again when the pointer is set back and popped once more.
- R6: While memory ready is low, the access is held with a stable address and the pointer does not change.
- R7: A command issued while pointer bits [2:0] are not zero is refused: no memory access, acknowledge one cycle later with `err_align` high, pointer unchanged; alignment is tested before the bound.
- R8: With the lower bound set, a push whose new pointer would be below the bound (unsigned) raises `err_ovf` with the acknowledge, issues no write, and leaves the pointer unchanged; a new pointer equal to the bound is allowed.
- R9: A push with the pointer below 8 always raises `err_ovf` and issues no write, whatever the bound.
- R10: While idle, `sp_load` sets the pointer on the next edge and takes priority over a pending request, which then starts one cycle later.
- R11: Acknowledge lasts exactly one cycle, fault flags are valid only with it, and the request is ignored during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sp_load | input | 1 | Load the pointer while idle |
| sp_load_val | input | ADDR_W | Value for pointer load |
| floor_set | input | 1 | Program and enable the lower bound |
| floor_val | input | ADDR_W | Lower bound value |
| cmd_req | input | 1 | Command request, held until acknowledge |
| cmd_pop | input | 1 | 1 = pop, 0 = push |
| cmd_data | input | DATA_W | Push operand |
| cmd_ack | output | 1 | One-cycle command acknowledge |
| rsp_data | output | DATA_W | Word returned by the last pop |
| err_align | output | 1 | Command refused, pointer misaligned |
| err_ovf | output | 1 | Push refused, bound or wrap |
| sp_o | output | ADDR_W | Current stack pointer |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, one cycle after accept |
| mem_ready | input | 1 | Memory accepts the access this cycle |

## Verification
The bench builds the block with its defaults: 64-bit pointer and data, giving an 8-byte step and 3 alignment bits, and with the lower bound present. The full-width pointer brings the wrap case at addresses 0 to 7 within reach alongside a bound sitting at a small address, so the equal-to-bound push, the below-bound push and the wrap push can all be driven next to each other. A small word memory model behind the port lets the bench see every write and check that refused pushes and pops leave memory alone.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RDWAIT = 2'd1,
        ST_ACK    = 2'd2
    } stk_state_e;

endpackage

// File: rtl/stk_floor_reg.sv
module stk_floor_reg #(
    parameter int ADDR_W    = 64,
    parameter bit HAS_FLOOR = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_i,
    input  logic [ADDR_W-1:0] val_i,
    output logic [ADDR_W-1:0] floor_o,
    output logic              en_o
);

    generate
        if (HAS_FLOOR) begin : g_floor
            typedef struct packed {
                logic [ADDR_W-1:0] val;
                logic              en;
            } floor_t;

            floor_t fl_d, fl_q;

            always_comb begin
                fl_d = fl_q;
                if (set_i) begin
                    fl_d.val = val_i;
                    fl_d.en  = 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    fl_q <= '0;
                end else begin
                    fl_q <= fl_d;
                end
            end

            assign floor_o = fl_q.val;
            assign en_o    = fl_q.en;
        end else begin : g_nofloor
            logic unused_floor_in;
            assign unused_floor_in = ^{clk, rst_n, set_i, val_i};
            assign floor_o = '0;
            assign en_o    = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/stk_addr_gen.sv
module stk_addr_gen #(
    parameter int ADDR_W = 64,
    parameter int STEP   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] sp_i,
    input  logic [ADDR_W-1:0] floor_i,
    input  logic              floor_en_i,
    output logic [ADDR_W-1:0] push_addr_o,
    output logic [ADDR_W-1:0] pop_next_o,
    output logic              misaligned_o,
    output logic              push_ovf_o
);

    localparam int LG2 = $clog2(STEP);
    localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STEP);

    logic wraps;
    logic below_floor;

    always_comb begin
        push_addr_o  = sp_i - STEP_A;
        pop_next_o   = sp_i + STEP_A;
        misaligned_o = (sp_i[LG2-1:0] != '0);
        wraps        = (sp_i < STEP_A);
        below_floor  = floor_en_i && (push_addr_o < floor_i);
        push_ovf_o   = wraps || below_floor;
    end

    // R9: a pointer below one step must always flag an overflow
    a_r9_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_i < STEP_A) |-> push_ovf_o);

    // R8: an accepted push never lands below an enabled bound
    a_r8_floor_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (floor_en_i && !push_ovf_o) |-> (push_addr_o >= floor_i));

endmodule

// File: rtl/stk_engine.sv
module stk_engine #(
    parameter int ADDR_W    = 64,
    parameter int DATA_W    = 64,
    parameter bit HAS_FLOOR = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sp_load,
    input  logic [ADDR_W-1:0] sp_load_val,
    input  logic              floor_set,
    input  logic [ADDR_W-1:0] floor_val,
    input  logic              cmd_req,
    input  logic              cmd_pop,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              cmd_ack,
    output logic [DATA_W-1:0] rsp_data,
    output logic              err_align,
    output logic              err_ovf,
    output logic [ADDR_W-1:0] sp_o,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    import stk_pkg::*;

    localparam int STEP = DATA_W / 8;
    localparam int LG2  = $clog2(STEP);
    localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STEP);

    typedef struct packed {
        stk_state_e        state;
        logic [ADDR_W-1:0] sp;
        logic [DATA_W-1:0] rdata;
        logic              e_align;
        logic              e_ovf;
    } eng_t;

    eng_t cur_q, nxt_d;

    logic [ADDR_W-1:0] floor_w;
    logic              floor_en_w;
    logic [ADDR_W-1:0] push_addr_w;
    logic [ADDR_W-1:0] pop_next_w;
    logic              misaligned_w;
    logic              push_ovf_w;

    stk_floor_reg #(
        .ADDR_W    (ADDR_W),
        .HAS_FLOOR (HAS_FLOOR)
    ) u_floor (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (floor_set),
        .val_i   (floor_val),
        .floor_o (floor_w),
        .en_o    (floor_en_w)
    );

    stk_addr_gen #(
        .ADDR_W (ADDR_W),
        .STEP   (STEP)
    ) u_addr (
        .clk          (clk),
        .rst_n        (rst_n),
        .sp_i         (cur_q.sp),
        .floor_i      (floor_w),
        .floor_en_i   (floor_en_w),
        .push_addr_o  (push_addr_w),
        .pop_next_o   (pop_next_w),
        .misaligned_o (misaligned_w),
        .push_ovf_o   (push_ovf_w)
    );

    always_comb begin
        nxt_d         = cur_q;
        nxt_d.e_align = 1'b0;
        nxt_d.e_ovf   = 1'b0;
        mem_en        = 1'b0;
        mem_we        = 1'b0;
        mem_addr      = cur_q.sp;
        mem_wdata     = cmd_data;

        unique case (cur_q.state)
            ST_IDLE: begin
                if (sp_load) begin
                    nxt_d.sp = sp_load_val;
                end else if (cmd_req) begin
                    if (misaligned_w) begin
                        nxt_d.e_align = 1'b1;
                        nxt_d.state   = ST_ACK;
                    end else if (!cmd_pop) begin
                        if (push_ovf_w) begin
                            nxt_d.e_ovf = 1'b1;
                            nxt_d.state = ST_ACK;
                        end else begin
                            mem_en   = 1'b1;
                            mem_we   = 1'b1;
                            mem_addr = push_addr_w;
                            if (mem_ready) begin
                                nxt_d.sp    = push_addr_w;
                                nxt_d.state = ST_ACK;
                            end
                        end
                    end else begin
                        mem_en = 1'b1;
                        if (mem_ready) begin
                            nxt_d.state = ST_RDWAIT;
                        end
                    end
                end
            end
            ST_RDWAIT: begin
                nxt_d.rdata = mem_rdata;
                nxt_d.sp    = pop_next_w;
                nxt_d.state = ST_ACK;
            end
            ST_ACK: begin
                nxt_d.state = ST_IDLE;
            end
            default: begin
                nxt_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_IDLE, sp: '0, rdata: '0, e_align: 1'b0, e_ovf: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign cmd_ack   = (cur_q.state == ST_ACK);
    assign rsp_data  = cur_q.rdata;
    assign err_align = cur_q.e_align;
    assign err_ovf   = cur_q.e_ovf;
    assign sp_o      = cur_q.sp;

    // R2: an accepted write moves the pointer onto the written address
    a_r2_push_moves_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && mem_ready) |=> (sp_o == $past(mem_addr)));

    // R2: the written word lies one step below the pointer
    a_r2_push_below_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> (mem_addr + STEP_A == sp_o));

    // R3: an accepted read raises the pointer one step by the acknowledge
    a_r3_pop_moves_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we && mem_ready) |=> ##1 (cmd_ack && sp_o == $past(mem_addr, 2) + STEP_A));

    // R6: a stalled access keeps pointer and address still
    a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_ready && cmd_req && !sp_load) |=> ($stable(sp_o) && mem_en && $stable(mem_addr)));

    // R7: every access is word aligned
    a_r7_aligned_access: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (mem_addr[LG2-1:0] == '0));

    // R8: no write below an enabled bound
    a_r8_no_write_below: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && floor_en_w) |-> (mem_addr >= floor_w));

    // R11: the acknowledge is a single-cycle pulse, flags only with it
    a_r11_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ack |=> !cmd_ack);

    a_r11_flags_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (err_align || err_ovf) |-> cmd_ack);

endmodule

// File: tb/stk_engine_tb.sv
module stk_engine_tb;

    localparam int AW = 64;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sp_load = 1'b0;
    logic [AW-1:0] sp_load_val = '0;
    logic          floor_set = 1'b0;
    logic [AW-1:0] floor_val = '0;
    logic          cmd_req = 1'b0;
    logic          cmd_pop = 1'b0;
    logic [DW-1:0] cmd_data = '0;
    logic          cmd_ack;
    logic [DW-1:0] rsp_data;
    logic          err_align;
    logic          err_ovf;
    logic [AW-1:0] sp_o;
    logic          mem_en;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_ready = 1'b1;

    int n_chk  = 0;
    int n_fail = 0;
    int n_wr   = 0;

    logic [DW-1:0] mem_model [32];

    always #2 clk = ~clk;

    stk_engine #(.ADDR_W(AW), .DATA_W(DW), .HAS_FLOOR(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .sp_load(sp_load), .sp_load_val(sp_load_val),
        .floor_set(floor_set), .floor_val(floor_val), .cmd_req(cmd_req),
        .cmd_pop(cmd_pop), .cmd_data(cmd_data), .cmd_ack(cmd_ack),
        .rsp_data(rsp_data), .err_align(err_align), .err_ovf(err_ovf),
        .sp_o(sp_o), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    always @(posedge clk) begin
        if (mem_en && mem_ready) begin
            if (mem_we) begin
                mem_model[mem_addr[7:3]] <= mem_wdata;
                n_wr <= n_wr + 1;
            end else begin
                mem_rdata <= mem_model[mem_addr[7:3]];
            end
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // issue one command and wait for the acknowledge; returns cycles to ack
    task automatic run_cmd(input logic pop, input logic [63:0] data, output int cyc);
        cmd_pop  = pop;
        cmd_data = data;
        cmd_req  = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!cmd_ack && cyc < 50);
        cmd_req = 1'b0;
    endtask

    task automatic load_sp(input logic [63:0] v);
        sp_load = 1'b1;
        sp_load_val = v;
        @(negedge clk);
        sp_load = 1'b0;
    endtask

    task automatic set_floor(input logic [63:0] v);
        floor_set = 1'b1;
        floor_val = v;
        @(negedge clk);
        floor_set = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 sp after reset", sp_o, 0);
        check("R1 ack after reset", cmd_ack, 0);
        check("R1 flags after reset", {err_align, err_ovf}, 0);
        check("R1 no access after reset", mem_en, 0);
    endtask

    task automatic t_example();
        int c;
        int w0;
        load_sp(64'h108);
        check("R10 load sets pointer", sp_o, 64'h108);
        w0 = n_wr;
        run_cmd(1'b0, 64'h123, c);
        check("R2 push ack latency", c, 1);
        check("R4 push pointer", sp_o, 64'h100);
        check("R4 push stored", mem_model[5'd0], 64'h123);
        check("R2 one write", n_wr - w0, 1);
        check("R11 no fault on push", {err_align, err_ovf}, 0);
        @(negedge clk);
        check("R11 ack one cycle", cmd_ack, 0);
        run_cmd(1'b1, 64'h0, c);
        check("R3 pop ack latency", c, 2);
        check("R4 pop data", rsp_data, 64'h123);
        check("R4 pop pointer", sp_o, 64'h108);
        @(negedge clk);
    endtask

    task automatic t_multi();
        int c;
        load_sp(64'h0C0);
        run_cmd(1'b0, 64'hA1A1_0000_0000_0001, c); @(negedge clk);
        run_cmd(1'b0, 64'hB2B2_0000_0000_0002, c); @(negedge clk);
        run_cmd(1'b0, 64'hC3C3_0000_0000_0003, c); @(negedge clk);
        check("R2 three pushes pointer", sp_o, 64'h0A8);
        run_cmd(1'b1, 0, c); @(negedge clk);
        check("R3 lifo first pop", rsp_data, 64'hC3C3_0000_0000_0003);
        run_cmd(1'b1, 0, c); @(negedge clk);
        check("R3 lifo second pop", rsp_data, 64'hB2B2_0000_0000_0002);
        check("R3 pointer after two pops", sp_o, 64'h0B8);
    endtask

    task automatic t_pop_keeps();
        int c;
        int w0;
        load_sp(64'h0A8);
        w0 = n_wr;
        run_cmd(1'b1, 0, c); @(negedge clk);
        check("R5 pop issues no write", n_wr - w0, 0);
        check("R5 word left in memory", mem_model[5'd21], 64'hC3C3_0000_0000_0003);
        load_sp(64'h0A8);
        run_cmd(1'b1, 0, c); @(negedge clk);
        check("R5 word popped again", rsp_data, 64'hC3C3_0000_0000_0003);
    endtask

    task automatic t_stall();
        int c;
        load_sp(64'h080);
        mem_ready = 1'b0;
        cmd_pop = 1'b0; cmd_data = 64'h5555; cmd_req = 1'b1;
        repeat (3) @(negedge clk);
        check("R6 pointer held in stall", sp_o, 64'h080);
        check("R6 access held", {mem_en, mem_we}, 2'b11);
        check("R6 address held", mem_addr, 64'h078);
        check("R6 no ack in stall", cmd_ack, 0);
        mem_ready = 1'b1;
        c = 0;
        do begin @(negedge clk); c++; end while (!cmd_ack && c < 50);
        cmd_req = 1'b0;
        check("R6 ack after release", c, 1);
        check("R6 pointer after release", sp_o, 64'h078);
        @(negedge clk);
        mem_ready = 1'b0;
        cmd_pop = 1'b1; cmd_req = 1'b1;
        repeat (2) @(negedge clk);
        check("R6 pop stall pointer", sp_o, 64'h078);
        mem_ready = 1'b1;
        c = 0;
        do begin @(negedge clk); c++; end while (!cmd_ack && c < 50);
        cmd_req = 1'b0;
        check("R6 pop data after stall", rsp_data, 64'h5555);
        check("R6 pop pointer after stall", sp_o, 64'h080);
        @(negedge clk);
    endtask

    task automatic t_align();
        int c;
        int w0;
        load_sp(64'h104);
        set_floor(64'h200);
        w0 = n_wr;
        run_cmd(1'b0, 64'h77, c);
        check("R7 refused push latency", c, 1);
        check("R7 align flag beats bound", {err_align, err_ovf}, 2'b10);
        check("R7 pointer kept", sp_o, 64'h104);
        check("R7 no write", n_wr - w0, 0);
        @(negedge clk);
        run_cmd(1'b1, 0, c);
        check("R7 refused pop", {c[1:0], err_align}, 3'b011);
        check("R7 pop pointer kept", sp_o, 64'h104);
        @(negedge clk);
    endtask

    task automatic t_floor();
        int c;
        int w0;
        set_floor(64'h100);
        load_sp(64'h110);
        run_cmd(1'b0, 64'h11, c); @(negedge clk);
        check("R8 push above bound", sp_o, 64'h108);
        run_cmd(1'b0, 64'h22, c);
        check("R8 push to bound allowed", {err_ovf, sp_o}, {1'b0, 64'h100});
        @(negedge clk);
        w0 = n_wr;
        run_cmd(1'b0, 64'h33, c);
        check("R8 below bound flagged", {err_align, err_ovf}, 2'b01);
        check("R8 pointer kept", sp_o, 64'h100);
        check("R8 no write", n_wr - w0, 0);
        check("R8 memory untouched", mem_model[5'd31], 64'h0);
        @(negedge clk);
    endtask

    task automatic t_wrap();
        int c;
        int w0;
        set_floor(64'h0);
        load_sp(64'h8);
        run_cmd(1'b0, 64'h44, c); @(negedge clk);
        check("R9 push to zero allowed", sp_o, 64'h0);
        w0 = n_wr;
        run_cmd(1'b0, 64'h55, c);
        check("R9 wrap flagged", err_ovf, 1);
        check("R9 wrap pointer kept", sp_o, 64'h0);
        check("R9 wrap no write", n_wr - w0, 0);
        @(negedge clk);
    endtask

    task automatic t_load_prio();
        int c;
        sp_load = 1'b1; sp_load_val = 64'h090;
        cmd_pop = 1'b0; cmd_data = 64'h99; cmd_req = 1'b1;
        @(negedge clk);
        sp_load = 1'b0;
        check("R10 load wins over request", {cmd_ack, sp_o}, {1'b0, 64'h090});
        c = 1;
        do begin @(negedge clk); c++; end while (!cmd_ack && c < 50);
        check("R10 request starts one later", c, 2);
        check("R10 push from loaded pointer", sp_o, 64'h088);
        @(negedge clk);
        check("R11 request ignored in ack cycle", sp_o, 64'h088);
        cmd_req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) mem_model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_example();
        t_multi();
        t_pop_keeps();
        t_stall();
        t_align();
        t_floor();
        t_wrap();
        t_load_prio();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule